// File: doc/BRIEF.md
# Synchronous Rectifier Gate Pair with Diode Emulation

This block drives the two gates of a switching power stage: a control switch (gate A) and a synchronous rectifier switch (gate B) that stands in for the freewheeling diode. A free-running counter defines the switching period. Gate A is high for the first `duty_a` counts of each period. Gate B turns on after A has turned off and a leading dead time has passed, and it turns off no later than a trailing dead time before the next period starts.

In complementary operation, B covers the whole interval A is off, less the two dead times. When diode emulation is enabled, the rectifier conduction interval is shortened to `duty_a * kd_ratio`, counted from the falling edge of A. This stops the rectifier before the inductor current would reverse in discontinuous conduction. Only B's falling edge moves. The multiplication is done in hardware every period from the live control duty, so software only has to reload the slowly changing ratio. When the product reaches the full off-time, B is held to the trailing limit and a per-period flag reports it to a conduction-mode monitor.

All inputs are plain control levels that are sampled at the period boundary. There is no data stream, and therefore no valid/ready handshake or back-pressure. Selecting the cycle-by-cycle fault mode forces complementary operation.

Top module: `sr_pwm_pair`

## Requirements
- R1: While `rst_n` is low, `gate_a`, `gate_b` and `full_off` are all low.
- R2: Each period lasts `period` clock cycles, and `gate_a` is high for exactly the first `duty_a` cycles of it, counted from its rising edge.
- R3: In complementary mode (`emul_en`=0, `sr_en`=1), `gate_b` rises `duty_a + dead_lead` cycles after the period start and stays high up to `period - dead_trail`, giving `period - dead_trail - duty_a - dead_lead` high cycles.
- R4: In emulation mode (`emul_en`=1, `cbc_mode`=0), the rise of `gate_b` is unchanged. Its fall is at `duty_a + floor(duty_a * kd_ratio / 4096)`, where `kd_ratio` is unsigned with 12 fractional bits (4096 = 1.0).
- R5: In emulation mode, the fall of `gate_b` is limited to `period - dead_trail`. `full_off` is high for the whole period exactly when the computed fall is at or beyond that limit.
- R6: With `cbc_mode`=1, the block behaves as in complementary mode whatever `emul_en` is, and `full_off` stays low.
- R7: All inputs are taken in only at the period boundary. A change in the middle of a period changes neither gate until the next period.
- R8: With `sr_en`=0, `gate_b` stays low for the whole period.
- R9: `gate_a` and `gate_b` are never high in the same cycle. If the computed fall does not come after the rise, `gate_b` stays low for that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | CNT_W | Switching period in clock cycles |
| duty_a | input | CNT_W | Control gate on-time in cycles |
| dead_lead | input | CNT_W | Gap from A falling to B rising |
| dead_trail | input | CNT_W | Gap from B falling to period end |
| kd_ratio | input | KD_W | Rectifier-to-control on-time ratio, 12 fractional bits |
| emul_en | input | 1 | Enable diode emulation |
| sr_en | input | 1 | Enable the rectifier gate |
| cbc_mode | input | 1 | Cycle-by-cycle fault mode selected; forces complementary operation |
| gate_a | output | 1 | Control switch gate |
| gate_b | output | 1 | Rectifier switch gate |
| full_off | output | 1 | Rectifier clamped to full off-time this period |

## Verification
The hardest case to reach from the ports is a ratio change that lands inside a running period. Catching it needs the bench to know where the period boundary is, although no port marks it. The stimulus locks onto the rising edge of `gate_a`. It then rewrites `duty_a` and `kd_ratio` a few cycles later, in the middle of the period, and measures both that period and the next one. The exact clamp boundary is reached with ratios chosen one code apart, so that the computed fall lands exactly on the trailing limit in one case and one cycle short of it in the other.

// File: rtl/sr_pwm_pkg.sv
package sr_pwm_pkg;

  // How the rectifier gate behaves for the current period
  typedef enum logic [1:0] {
    BMODE_OFF  = 2'd0,  // rectifier held low
    BMODE_COMP = 2'd1,  // full complementary window
    BMODE_EMUL = 2'd2   // window shortened by the duty ratio
  } b_mode_e;

endpackage

// File: rtl/sr_period_timer.sv
module sr_period_timer
  import sr_pwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int KD_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty_a,
  input  logic [CNT_W-1:0] dead_lead,
  input  logic [CNT_W-1:0] dead_trail,
  input  logic [KD_W-1:0]  kd_ratio,
  input  logic             emul_en,
  input  logic             sr_en,
  input  logic             cbc_mode,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] da_q,
  output logic [CNT_W-1:0] dl_q,
  output logic [CNT_W-1:0] dt_q,
  output logic [KD_W-1:0]  kd_q,
  output b_mode_e          mode_q
);
  localparam int EW = CNT_W + 1;

  b_mode_e mode_d;

  // A zero period right after reset also counts as a boundary, so the first
  // edge out of reset loads the settings.
  assign wrap = ({1'b0, cnt} + EW'(1)) >= {1'b0, per_q};

  always_comb begin
    if (!sr_en)                   mode_d = BMODE_OFF;
    else if (emul_en && !cbc_mode) mode_d = BMODE_EMUL;
    else                          mode_d = BMODE_COMP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= '0;
      da_q   <= '0;
      dl_q   <= '0;
      dt_q   <= '0;
      kd_q   <= '0;
      mode_q <= BMODE_OFF;
    end else if (wrap) begin
      cnt    <= '0;
      per_q  <= period;
      da_q   <= duty_a;
      dl_q   <= dead_lead;
      dt_q   <= dead_trail;
      kd_q   <= kd_ratio;
      mode_q <= mode_d;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sr_edge_calc.sv
module sr_edge_calc
  import sr_pwm_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int KD_W    = 16,
  parameter int KD_FRAC = 12
) (
  input  logic [CNT_W-1:0] per_q,
  input  logic [CNT_W-1:0] da_q,
  input  logic [CNT_W-1:0] dl_q,
  input  logic [CNT_W-1:0] dt_q,
  input  logic [KD_W-1:0]  kd_q,
  input  b_mode_e          mode_q,
  output logic [CNT_W:0]   b_rise,
  output logic [CNT_W:0]   b_fall,
  output logic             full_off
);
  localparam int PW = CNT_W + KD_W;
  localparam int EW = CNT_W + 1;

  logic [PW-1:0]    prod;
  logic [PW-1:0]    scaled;
  logic [CNT_W-1:0] db;
  logic [EW-1:0]    lim;
  logic [EW-1:0]    emul_fall;

  // Rectifier on-time = control duty times ratio, dropping the fraction
  assign prod   = PW'(da_q) * PW'(kd_q);
  assign scaled = prod >> KD_FRAC;
  assign db     = (|scaled[PW-1:CNT_W]) ? {CNT_W{1'b1}} : scaled[CNT_W-1:0];

  assign lim       = (dt_q >= per_q) ? '0 : {1'b0, per_q - dt_q};
  assign b_rise    = {1'b0, da_q} + {1'b0, dl_q};
  assign emul_fall = {1'b0, da_q} + {1'b0, db};

  always_comb begin
    b_fall   = '0;
    full_off = 1'b0;
    case (mode_q)
      BMODE_COMP: b_fall = lim;
      BMODE_EMUL: begin
        if (emul_fall >= lim) begin
          b_fall   = lim;
          full_off = 1'b1;
        end else begin
          b_fall = emul_fall;
        end
      end
      default: b_fall = '0;
    endcase
  end

endmodule

// File: rtl/sr_gate_decode.sv
module sr_gate_decode #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] da_q,
  input  logic [CNT_W:0]   b_rise,
  input  logic [CNT_W:0]   b_fall,
  output logic             gate_a,
  output logic             gate_b
);
  logic [CNT_W:0] cnt_e;

  assign cnt_e  = {1'b0, cnt};
  assign gate_a = cnt < da_q;
  // The rise is never before the end of A, so the pair cannot overlap
  assign gate_b = (cnt_e >= b_rise) && (cnt_e < b_fall);

endmodule

// File: rtl/sr_pwm_pair.sv
module sr_pwm_pair
  import sr_pwm_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int KD_W    = 16,
  parameter int KD_FRAC = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty_a,
  input  logic [CNT_W-1:0] dead_lead,
  input  logic [CNT_W-1:0] dead_trail,
  input  logic [KD_W-1:0]  kd_ratio,
  input  logic             emul_en,
  input  logic             sr_en,
  input  logic             cbc_mode,
  output logic             gate_a,
  output logic             gate_b,
  output logic             full_off
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] da_q;
  logic [CNT_W-1:0] dl_q;
  logic [CNT_W-1:0] dt_q;
  logic [KD_W-1:0]  kd_q;
  b_mode_e          mode_q;
  logic [CNT_W:0]   b_rise;
  logic [CNT_W:0]   b_fall;

  sr_period_timer #(.CNT_W(CNT_W), .KD_W(KD_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .period     (period),
    .duty_a     (duty_a),
    .dead_lead  (dead_lead),
    .dead_trail (dead_trail),
    .kd_ratio   (kd_ratio),
    .emul_en    (emul_en),
    .sr_en      (sr_en),
    .cbc_mode   (cbc_mode),
    .cnt        (cnt),
    .wrap       (wrap),
    .per_q      (per_q),
    .da_q       (da_q),
    .dl_q       (dl_q),
    .dt_q       (dt_q),
    .kd_q       (kd_q),
    .mode_q     (mode_q)
  );

  sr_edge_calc #(.CNT_W(CNT_W), .KD_W(KD_W), .KD_FRAC(KD_FRAC)) u_calc (
    .per_q    (per_q),
    .da_q     (da_q),
    .dl_q     (dl_q),
    .dt_q     (dt_q),
    .kd_q     (kd_q),
    .mode_q   (mode_q),
    .b_rise   (b_rise),
    .b_fall   (b_fall),
    .full_off (full_off)
  );

  sr_gate_decode #(.CNT_W(CNT_W)) u_decode (
    .cnt    (cnt),
    .da_q   (da_q),
    .b_rise (b_rise),
    .b_fall (b_fall),
    .gate_a (gate_a),
    .gate_b (gate_b)
  );

endmodule

// File: rtl/sr_pwm_pair_chk.sv
module sr_pwm_pair_chk
  import sr_pwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int KD_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_a,
  input logic             gate_b,
  input logic             full_off,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic [CNT_W-1:0] per_q,
  input logic [CNT_W-1:0] da_q,
  input logic [CNT_W-1:0] dt_q,
  input logic [KD_W-1:0]  kd_q,
  input b_mode_e          mode_q
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a && gate_b)); // R9

  AST_A_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && da_q != '0) |-> gate_a); // R2

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) |-> (cnt < per_q)); // R2

  AST_TRAIL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_q < per_q && cnt >= per_q - dt_q) |-> !gate_b); // R5

  AST_SR_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BMODE_OFF) |-> !gate_b); // R8

  AST_HOLD_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(kd_q) && $stable(da_q) && $stable(per_q))); // R7

  AST_FLAG_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(full_off)); // R5

  AST_FLAG_EMUL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    full_off |-> (mode_q == BMODE_EMUL)); // R6

endmodule

bind sr_pwm_pair sr_pwm_pair_chk #(.CNT_W(CNT_W), .KD_W(KD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate_a   (gate_a),
  .gate_b   (gate_b),
  .full_off (full_off),
  .cnt      (cnt),
  .wrap     (wrap),
  .per_q    (per_q),
  .da_q     (da_q),
  .dt_q     (dt_q),
  .kd_q     (kd_q),
  .mode_q   (mode_q)
);

// File: tb/sr_pwm_pair_test.sv
module sr_pwm_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int KD_W  = 16;
  localparam int NV    = 13;
  localparam int NF    = 11;

  // per, da, dl, dt, kd, emul, cbc, sr, exp_b_start, exp_b_len, exp_flag
  localparam int VT [NV][NF] = '{
    '{100, 30, 3, 4,     0, 0, 0, 1,  33, 63, 0},  // R3 complementary
    '{100, 30, 3, 4,  4096, 1, 0, 1,  33, 27, 0},  // R4 ratio 1.0
    '{100, 30, 3, 4,  2048, 1, 0, 1,  33, 12, 0},  // R4 ratio 0.5
    '{100, 30, 3, 4, 12288, 1, 0, 1,  33, 63, 1},  // R5 ratio 3.0 clamps
    '{100, 30, 3, 4,  4096, 1, 1, 1,  33, 63, 0},  // R6 fault mode forces comp
    '{ 50, 10, 2, 2,  6144, 1, 0, 1,  12, 13, 0},  // R4 ratio 1.5
    '{ 50, 20, 0, 0,  4096, 1, 0, 1,  20, 20, 0},  // R4 no dead times
    '{100, 30, 5, 4,   409, 1, 0, 1,  -1,  0, 0},  // R9 fall before rise
    '{100, 30, 3, 4,  1365, 1, 0, 1,  33,  6, 0},  // R4 truncation
    '{ 64, 40, 2, 2,     0, 0, 0, 1,  42, 20, 0},  // R3 other period
    '{100, 30, 3, 4,     0, 0, 0, 0,  -1,  0, 0},  // R8 rectifier off
    '{100, 30, 3, 4,  9012, 1, 0, 1,  33, 63, 1},  // R5 fall lands on limit
    '{100, 30, 3, 4,  9011, 1, 0, 1,  33, 62, 0}   // R5 one short of limit
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] period = '0;
  logic [CNT_W-1:0] duty_a = '0;
  logic [CNT_W-1:0] dead_lead = '0;
  logic [CNT_W-1:0] dead_trail = '0;
  logic [KD_W-1:0]  kd_ratio = '0;
  logic             emul_en = 1'b0;
  logic             sr_en = 1'b0;
  logic             cbc_mode = 1'b0;
  logic             gate_a;
  logic             gate_b;
  logic             full_off;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  sr_pwm_pair #(.CNT_W(CNT_W), .KD_W(KD_W), .KD_FRAC(12)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .period     (period),
    .duty_a     (duty_a),
    .dead_lead  (dead_lead),
    .dead_trail (dead_trail),
    .kd_ratio   (kd_ratio),
    .emul_en    (emul_en),
    .sr_en      (sr_en),
    .cbc_mode   (cbc_mode),
    .gate_a     (gate_a),
    .gate_b     (gate_b),
    .full_off   (full_off)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input int per, input int da, input int dl, input int dt,
                       input int kd, input int de, input int cbc, input int sr);
    period     = CNT_W'(per);
    duty_a     = CNT_W'(da);
    dead_lead  = CNT_W'(dl);
    dead_trail = CNT_W'(dt);
    kd_ratio   = KD_W'(kd);
    emul_en    = (de != 0);
    cbc_mode   = (cbc != 0);
    sr_en      = (sr != 0);
  endtask

  // Locks to the rising edge of gate_a, then samples one full period.
  // If chg_at >= 0, duty_a and kd_ratio are rewritten after that sample.
  task automatic measure(input int per, input int chg_at, input int new_da, input int new_kd,
                         output int a_len, output int b_start, output int b_len,
                         output int flag_cnt, output int ovl);
    logic prev;
    int guard;
    a_len = 0; b_start = -1; b_len = 0; flag_cnt = 0; ovl = 0; guard = 0;
    @(negedge clk);
    prev = gate_a;
    forever begin
      @(negedge clk);
      if (gate_a && !prev) break;
      prev = gate_a;
      guard++;
      if (guard > 5000) break;
    end
    for (int i = 0; i < per; i++) begin
      if (gate_a) a_len++;
      if (gate_b) begin
        if (b_start < 0) b_start = i;
        b_len++;
      end
      if (full_off) flag_cnt++;
      if (gate_a && gate_b) ovl++;
      if (i == chg_at) begin
        duty_a   = CNT_W'(new_da);
        kd_ratio = KD_W'(new_kd);
      end
      if (i < per - 1) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a_len, b_start, b_len, flag_cnt, ovl;
    string tag;

    // R1: outputs held low during reset even with settings applied
    apply(100, 30, 3, 4, 12288, 1, 0, 1);
    repeat (5) @(negedge clk);
    chk("R1", "gate_a in reset", int'(gate_a), 0);
    chk("R1", "gate_b in reset", int'(gate_b), 0);
    chk("R1", "full_off in reset", int'(full_off), 0);
    rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < NV; v++) begin
      apply(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4], VT[v][5], VT[v][6], VT[v][7]);
      repeat (220) @(negedge clk);
      measure(VT[v][0], -1, 0, 0, a_len, b_start, b_len, flag_cnt, ovl);
      if (VT[v][7] == 0)      tag = "R8";
      else if (VT[v][6] != 0) tag = "R6";
      else if (VT[v][5] != 0) tag = "R4";
      else                    tag = "R3";
      chk("R2", $sformatf("vec%0d gate_a width", v), a_len, VT[v][1]);
      chk(tag, $sformatf("vec%0d gate_b width", v), b_len, VT[v][9]);
      if (VT[v][9] > 0)
        chk(tag, $sformatf("vec%0d gate_b start", v), b_start, VT[v][8]);
      chk("R5", $sformatf("vec%0d full_off cycles", v), flag_cnt, VT[v][10] * VT[v][0]);
      chk("R9", $sformatf("vec%0d overlap cycles", v), ovl, 0);
    end

    // R7: mid-period rewrite of duty and ratio takes effect only next period
    apply(100, 30, 3, 4, 4096, 1, 0, 1);
    repeat (220) @(negedge clk);
    measure(100, 5, 40, 12288, a_len, b_start, b_len, flag_cnt, ovl);
    chk("R7", "gate_a width in changed period", a_len, 30);
    chk("R7", "gate_b width in changed period", b_len, 27);
    chk("R7", "full_off in changed period", flag_cnt, 0);
    measure(100, -1, 0, 0, a_len, b_start, b_len, flag_cnt, ovl);
    chk("R7", "gate_a width after boundary", a_len, 40);
    chk("R7", "gate_b start after boundary", b_start, 43);
    chk("R7", "gate_b width after boundary", b_len, 53);
    chk("R7", "full_off after boundary", flag_cnt, 100);

    // R1: reset asserted mid-run clears the outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "gate_a after reset", int'(gate_a), 0);
    chk("R1", "gate_b after reset", int'(gate_b), 0);
    chk("R1", "full_off after reset", int'(full_off), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule